// File: doc/BRIEF.md
# Flag and Condition Select Unit

This unit keeps the three status flags of a microcoded datapath (carry, zero and negative) and one conditional-execution flag F. Each status flag has its own update enable in the current micro-instruction. When the enable is high, the flag loads from the ALU. When the enable is low, the flag keeps its value. The flags are never handled as a byte. Saving or restoring them goes one flag at a time, through the condition path and the ALU.

A 3-bit select picks one of eight conditions. The selected condition goes, in the same cycle, to the ALU as its carry-in for the adder and the right shifter. When the F write enable is high, the condition is also latched into F at the clock edge. The select and the F write enable are wired to the microcode ROM output, ahead of the microcode register. As a result, F is already updated at the edge that ends the fetch, and the following fetch can branch on it. A conditional micro-step therefore takes two cycles instead of three.

Top module: `flag_cond_unit`

## Requirements
- R1: While rst_ni is low, flag_c_o, flag_z_o, flag_n_o and flag_f_o are 0.
- R2: At a clock edge with upd_c_i high, flag_c_o takes alu_cout_i. With upd_c_i low, it keeps its value.
- R3: At a clock edge with upd_z_i high, flag_z_o becomes 1 if alu_res_i is all zeros and 0 otherwise. With upd_z_i low, it keeps its value.
- R4: At a clock edge with upd_n_i high, flag_n_o takes the most significant bit of alu_res_i. With upd_n_i low, it keeps its value.
- R5: cond_o follows cond_sel_i in the same cycle, with no clock edge in between. The codes are: 0 gives constant 0, 1 gives constant 1, 2 gives C, 3 gives Z, 4 gives N, 5 gives not C, 6 gives not Z, 7 gives not N. The value of f_wr_i has no effect on cond_o.
- R6: At a clock edge with f_wr_i high, flag_f_o takes the value cond_o had just before that edge. With f_wr_i low, it keeps its value.
- R7: When a status flag and F are written at the same edge, F takes the condition computed from the flag value held before that edge.
- R8: A select presented on the ROM-side inputs shows on flag_f_o after exactly one clock edge. A copy of the select that passes through the micro-instruction register would need two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_c_i | input | 1 | Load carry flag |
| upd_z_i | input | 1 | Load zero flag |
| upd_n_i | input | 1 | Load negative flag |
| alu_cout_i | input | 1 | ALU carry result |
| alu_res_i | input | DATA_W | ALU result byte |
| cond_sel_i | input | 3 | Condition select, from the ROM output |
| f_wr_i | input | 1 | F write enable, from the ROM output |
| cond_o | output | 1 | Selected condition, used as the ALU carry-in |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_f_o | output | 1 | Conditional-execution flag |

## Verification
A status flag that loads or holds wrongly shows on its own output one edge later. Through cond_o, it also shows in the same cycle, for every select code that reads that flag. An F that latches at the wrong time, or latches the post-update flag value, shows on flag_f_o one edge after the write. The bench compares F against a one-edge model and checks that it does not match a model with a registered select. Random select codes with both polarities reach every mux leg, so a swapped or inverted leg changes cond_o right away.

// File: rtl/flag_cond_pkg.sv
package flag_cond_pkg;
  typedef enum logic [2:0] {
    COND_ZERO  = 3'd0,
    COND_ONE   = 3'd1,
    COND_C     = 3'd2,
    COND_Z     = 3'd3,
    COND_N     = 3'd4,
    COND_NC    = 3'd5,
    COND_NZ    = 3'd6,
    COND_NN    = 3'd7
  } cond_e;

  localparam int unsigned NUM_STAT = 3;
  localparam int unsigned IDX_C = 0;
  localparam int unsigned IDX_Z = 1;
  localparam int unsigned IDX_N = 2;
endpackage

// File: rtl/flag_bit.sv
module flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/cond_mux.sv
module cond_mux
  import flag_cond_pkg::*;
(
  input  logic [2:0]          sel_i,
  input  logic [NUM_STAT-1:0] stat_i,
  output logic                cond_o
);
  always_comb begin
    unique case (cond_e'(sel_i))
      COND_ZERO: cond_o = 1'b0;
      COND_ONE:  cond_o = 1'b1;
      COND_C:    cond_o = stat_i[IDX_C];
      COND_Z:    cond_o = stat_i[IDX_Z];
      COND_N:    cond_o = stat_i[IDX_N];
      COND_NC:   cond_o = ~stat_i[IDX_C];
      COND_NZ:   cond_o = ~stat_i[IDX_Z];
      default:   cond_o = ~stat_i[IDX_N];
    endcase
  end
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import flag_cond_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_c_i,
  input  logic              upd_z_i,
  input  logic              upd_n_i,
  input  logic              alu_cout_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [2:0]        cond_sel_i,
  input  logic              f_wr_i,
  output logic              cond_o,
  output logic              flag_c_o,
  output logic              flag_z_o,
  output logic              flag_n_o,
  output logic              flag_f_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [NUM_STAT-1:0] ld, d, q;

  assign ld[IDX_C] = upd_c_i;
  assign ld[IDX_Z] = upd_z_i;
  assign ld[IDX_N] = upd_n_i;
  assign d[IDX_C]  = alu_cout_i;
  assign d[IDX_Z]  = ~|alu_res_i;
  assign d[IDX_N]  = alu_res_i[MSB];

  for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
    flag_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (ld[i]),
      .d_i   (d[i]),
      .q_o   (q[i])
    );
  end

  // select comes straight from ROM output: evaluated against pre-edge flags
  cond_mux u_mux (
    .sel_i (cond_sel_i),
    .stat_i(q),
    .cond_o(cond_o)
  );

  flag_bit u_f (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (f_wr_i),
    .d_i   (cond_o),
    .q_o   (flag_f_o)
  );

  assign flag_c_o = q[IDX_C];
  assign flag_z_o = q[IDX_Z];
  assign flag_n_o = q[IDX_N];
endmodule

// File: rtl/flag_cond_unit_chk.sv
module flag_cond_unit_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_c_i,
  input logic              upd_z_i,
  input logic              upd_n_i,
  input logic              alu_cout_i,
  input logic [DATA_W-1:0] alu_res_i,
  input logic [2:0]        cond_sel_i,
  input logic              f_wr_i,
  input logic              cond_o,
  input logic              flag_c_o,
  input logic              flag_z_o,
  input logic              flag_n_o,
  input logic              flag_f_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert ({flag_c_o, flag_z_o, flag_n_o, flag_f_o} == 4'b0);
    end
  end

  // R2
  c_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_c_i |=> flag_c_o == $past(alu_cout_i));
  // R2
  c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_c_i |=> $stable(flag_c_o));
  // R3
  z_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_z_i |=> flag_z_o == ($past(alu_res_i) == '0));
  // R4
  n_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_n_i |=> flag_n_o == $past(alu_res_i[DATA_W-1]));
  // R5
  cond_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_sel_i == 3'd2 |-> cond_o == flag_c_o);
  // R5
  cond_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_sel_i == 3'd6 |-> cond_o == !flag_z_o);
  // R6
  f_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_wr_i |=> flag_f_o == $past(cond_o));
  // R6
  f_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !f_wr_i |=> $stable(flag_f_o));
  // R7
  f_old_c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_wr_i && cond_sel_i == 3'd2) |=> flag_f_o == $past(flag_c_o));
endmodule

bind flag_cond_unit flag_cond_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/flag_cond_unit_test.sv
module flag_cond_unit_test;
  localparam int unsigned DATA_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic upd_c, upd_z, upd_n, cout, f_wr;
  logic [DATA_W-1:0] res;
  logic [2:0] sel;
  logic cond, fc, fz, fn, ff;

  int total = 0;
  int bad = 0;

  logic mc, mz, mn, mf;     // one-edge model
  logic rsel_v, rwr, rf;    // registered-select reference
  logic [2:0] rsel;

  always #5 clk = ~clk;

  flag_cond_unit #(.DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .upd_c_i(upd_c), .upd_z_i(upd_z), .upd_n_i(upd_n),
    .alu_cout_i(cout), .alu_res_i(res),
    .cond_sel_i(sel), .f_wr_i(f_wr),
    .cond_o(cond), .flag_c_o(fc), .flag_z_o(fz), .flag_n_o(fn), .flag_f_o(ff)
  );

  function automatic logic exp_cond(input logic [2:0] s, input logic c, z, n);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return c;
      3'd3: return z;
      3'd4: return n;
      3'd5: return ~c;
      3'd6: return ~z;
      default: return ~n;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " C"}, fc, mc);
    check({tag, " Z"}, fz, mz);
    check({tag, " N"}, fn, mn);
    check({tag, " F"}, ff, mf);
  endtask

  // drive at negedge, check cond_o, then advance model at posedge
  task automatic step(input logic uc, uz, un, co, input logic [DATA_W-1:0] r,
                      input logic [2:0] s, input logic w);
    logic nc, nz, nn, nf, e;
    upd_c = uc; upd_z = uz; upd_n = un; cout = co; res = r; sel = s; f_wr = w;
    #1;
    e = exp_cond(s, mc, mz, mn);
    check("R5 cond", cond, e);
    nc = uc ? co : mc;
    nz = uz ? (r == '0) : mz;
    nn = un ? r[DATA_W-1] : mn;
    nf = w ? e : mf;
    @(posedge clk);
    // reference with select passing through a register
    if (rsel_v && rwr) rf = exp_cond(rsel, mc, mz, mn);
    rsel = s; rwr = w; rsel_v = 1'b1;
    mc = nc; mz = nz; mn = nn; mf = nf;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    upd_c = 0; upd_z = 0; upd_n = 0; cout = 0; res = '0; sel = '0; f_wr = 0;
    mc = 0; mz = 0; mn = 0; mf = 0; rf = 0; rsel = '0; rwr = 0; rsel_v = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);

    // R2/R3/R4 directed loads and holds
    step(1, 1, 1, 1, 8'h00, 3'd0, 0); check_all("R2 R3 load");
    step(0, 1, 1, 0, 8'h80, 3'd0, 0); check_all("R4 N msb, R2 hold");
    step(0, 0, 0, 0, 8'h00, 3'd0, 0); check_all("R2 R3 R4 hold");

    // R5: f_wr does not change cond_o; R6 hold with f_wr low
    for (int s = 0; s < 8; s++) begin
      step(0, 0, 0, 0, 8'h11, 3'(s), 0); check("R6 hold", ff, mf);
      step(0, 0, 0, 0, 8'h11, 3'(s), 1); check("R6 load", ff, mf);
    end

    // R7: C goes 1->0 while F samples C in same edge: F gets old 1
    step(1, 0, 0, 1, 8'h01, 3'd0, 0);
    step(1, 0, 0, 0, 8'h01, 3'd2, 1);
    check("R7 old C", ff, 1'b1);
    check("R7 new C", fc, 1'b0);

    // R8: F ready after one edge; registered-select path lags
    step(0, 0, 0, 0, 8'h01, 3'd1, 1);
    check("R8 one-edge F", ff, 1'b1);
    check("R8 reference still lags", rf, 1'b0);
    step(0, 0, 0, 0, 8'h01, 3'd0, 1);
    check("R8 one-edge F clr", ff, 1'b0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [DATA_W-1:0] r;
      r = ($urandom % 4 == 0) ? '0 : DATA_W'($urandom);
      step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), r,
           3'($urandom), 1'($urandom));
      check_all("R2 R3 R4 R6 random");
    end

    // R1 async reset mid-run
    rst_ni = 1'b0; #1;
    mc = 0; mz = 0; mn = 0; mf = 0;
    check_all("R1 mid reset");
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule